// File: doc/BRIEF.md
# Two-Slot Interleaved Biphase-Mark Line Encoder

This block merges two single-bit serial channels onto one self-clocking line. The first channel carries trigger decisions and the second carries command and data bits. Every basic period is split into two bit cells: the first cell holds the trigger bit and the second holds the command bit. The stream of cells is then biphase-mark coded. The line changes level at the start of every cell, and changes again halfway through a cell only when that cell's bit is 1. A receiver can therefore recover the basic clock, the cell boundaries and both channels from one wire.

The block runs from a single clock at four times the basic rate. The basic rate may be anything the fast clock allows. A free-running two-bit phase count numbers the four half-cells of a period. Reset clears the count, so the first period starts right after reset. Both channel bits are captured together once per period and held for the whole period. The block also drives a one-cycle strobe at the start of each period, so upstream and downstream logic can align to it.

The line cannot pause, so the channel inputs have no valid/ready handshake. The strobe acts as the only "ready": a source must present its next pair of bits in the cycle just before the strobe rises. It has no way to apply back-pressure and no way to skip a period. An idle source drives trigger 0 and command 1. An input that is not connected reads as 0.

Top module: `tdm_bpm_encoder`

## Requirements
- R1: While `rst` is high, `line_out` and `period_stb` are both 0.
- R2: After reset is released, `period_stb` is high for exactly one fast cycle in every four. It first rises on the fourth rising edge after release.
- R3: `line_out` changes level on the edge at which each cell begins. Cell starts fall at half-cell 0 (trigger cell) and half-cell 2 (command cell). Half-cell 0 is the cycle in which `period_stb` is high.
- R4: `line_out` changes level on the edge entering half-cell 1 if and only if the captured trigger bit is 1. It changes on the edge entering half-cell 3 if and only if the captured command bit is 1.
- R5: `ch_trig` and `ch_cmd` are captured only on the edge at which `period_stb` rises. That is, the block takes the values present in half-cell 3 of the previous period. Values at any other time have no effect on the line.
- R6: Latency is fixed, counted in fast cycles from the capture edge: the trigger cell starts at +0, its mid-cell at +1, the command cell starts at +2 and its mid-cell is at +3.
- R7: The held bits reset to 0. So in the partial period right after reset, `line_out` reads 0, 1, 1 in the three cycles following release, whatever the inputs are.
- R8: With the idle input trigger 0 and command 1, each period has three level changes. The line pattern therefore inverts from one period to the next and repeats exactly every two periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_4x | input | 1 | Fast clock at four times the basic rate |
| rst | input | 1 | Synchronous reset, active high |
| ch_trig | input | 1 | Trigger channel bit, sampled once per period |
| ch_cmd | input | 1 | Command/data channel bit, sampled once per period |
| line_out | output | 1 | Biphase-mark coded, interleaved line |
| period_stb | output | 1 | One-cycle strobe marking half-cell 0 of each period |

## Verification
The hardest case to reach from the ports is a channel input that changes while a period is already on the line. To reach it, the stimulus redraws both inputs at random in every fast cycle. Only the value in half-cell 3 is recorded as the expected pair, and the decoded cells must match that value alone. Two further cases need directed stimulus. The partial first period after reset is driven with both inputs at 1, to show that nothing leaks through before the first capture. The idle pattern check needs three idle periods in a row before periodicity can be judged, so a long idle stretch is applied on purpose.

// File: rtl/bpm_enc_pkg.sv
package bpm_enc_pkg;
  // Number of bit cells per basic period and half-cells per cell.
  localparam int unsigned SLOT_COUNT  = 2;
  localparam int unsigned HALF_PER_SLOT = 2;
  localparam int unsigned PHASE_COUNT = SLOT_COUNT * HALF_PER_SLOT;
  localparam int unsigned PHASE_W     = $clog2(PHASE_COUNT);

  // Captured bit pair: slot 0 (trigger) in the low bit.
  typedef struct packed {
    logic cmd;
    logic trig;
  } slot_pair_t;
endpackage

// File: rtl/bpm_phase_gen.sv
module bpm_phase_gen #(
  parameter int unsigned PHASES = 4,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic          capture_en,
  output logic          period_stb
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] cnt_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
      stb_q <= (cnt_q == LAST);
    end
  end

  assign phase      = cnt_q;
  assign capture_en = (cnt_q == LAST);
  assign period_stb = stb_q;

  // R2: strobe never lasts two cycles
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> !period_stb);
  // R2: strobe only in half-cell 0
  a_r2_strobe_phase: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> (phase == '0));
endmodule

// File: rtl/bpm_slot_sampler.sv
module bpm_slot_sampler #(
  parameter int unsigned SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_en,
  input  logic [SLOTS-1:0] slot_in,
  output logic [SLOTS-1:0] slot_held
);
  logic [SLOTS-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)             held_q <= '0;
    else if (capture_en) held_q <= slot_in;
  end

  assign slot_held = held_q;

  // R5: held bits only move at the capture edge
  a_r5_hold_between_captures: assert property (@(posedge clk) disable iff (rst)
    !capture_en |=> $stable(slot_held));
endmodule

// File: rtl/bpm_line_coder.sv
module bpm_line_coder #(
  parameter int unsigned SLOTS = 2,
  localparam int unsigned PHASES = SLOTS * 2,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    phase,
  input  logic [SLOTS-1:0] slot_bits,
  output logic             line
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] next_ph;
  logic          flip;
  logic          line_q;

  // Decide on the half-cell being entered at the coming edge.
  always_comb begin
    next_ph = (phase == LAST) ? '0 : phase + PW'(1);
    if (next_ph[0] == 1'b0) flip = 1'b1;                       // cell start
    else                    flip = slot_bits[next_ph[PW-1:1]]; // mid-cell
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= line_q ^ flip;
  end

  assign line = line_q;

  // R3: every entry into a cell-start half-cell changes the level
  a_r3_cell_start_toggle: assert property (@(posedge clk) disable iff (rst)
    (phase[0] == 1'b1) |=> (line != $past(line)));
  // R4: mid-cell change iff the slot's held bit is 1
  a_r4_mid_cell_data: assert property (@(posedge clk) disable iff (rst)
    (phase[0] == 1'b0) |=> ((line ^ $past(line)) == $past(slot_bits[phase[PW-1:1]])));
endmodule

// File: rtl/tdm_bpm_encoder.sv
module tdm_bpm_encoder
  import bpm_enc_pkg::*;
(
  input  logic clk_4x,
  input  logic rst,
  input  logic ch_trig,
  input  logic ch_cmd,
  output logic line_out,
  output logic period_stb
);
  logic [PHASE_W-1:0] phase;
  logic               capture_en;
  slot_pair_t         pair_in;
  slot_pair_t         pair_held;

  assign pair_in.trig = ch_trig;
  assign pair_in.cmd  = ch_cmd;

  bpm_phase_gen #(.PHASES(PHASE_COUNT)) u_phase (
    .clk        (clk_4x),
    .rst        (rst),
    .phase      (phase),
    .capture_en (capture_en),
    .period_stb (period_stb)
  );

  bpm_slot_sampler #(.SLOTS(SLOT_COUNT)) u_sampler (
    .clk        (clk_4x),
    .rst        (rst),
    .capture_en (capture_en),
    .slot_in    (pair_in),
    .slot_held  (pair_held)
  );

  bpm_line_coder #(.SLOTS(SLOT_COUNT)) u_coder (
    .clk       (clk_4x),
    .rst       (rst),
    .phase     (phase),
    .slot_bits (pair_held),
    .line      (line_out)
  );

  // R1: outputs quiet during reset (checked from the second reset cycle on)
  a_r1_reset_quiet: assert property (@(posedge clk_4x)
    $past(rst) |-> (!line_out && !period_stb));
  // R6: the trigger cell starts on the same edge as the strobe
  a_r6_capture_alignment: assert property (@(posedge clk_4x) disable iff (rst)
    $rose(period_stb) |-> (line_out != $past(line_out)));
endmodule

// File: tb/tdm_bpm_encoder_tb_top.sv
module tdm_bpm_encoder_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic trig_i, cmd_i;
  logic line_o, stb_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tdm_bpm_encoder dut_i (
    .clk_4x(clk), .rst(rst), .ch_trig(trig_i), .ch_cmd(cmd_i),
    .line_out(line_o), .period_stb(stb_o)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected line levels for one period from the prior level and the pair.
  function automatic logic [3:0] exp_levels(input logic prev, input logic t, input logic c);
    logic [3:0] v;
    v[0] = ~prev;
    v[1] = t ? ~v[0] : v[0];
    v[2] = ~v[1];
    v[3] = c ? ~v[2] : v[2];
    return v;
  endfunction

  initial begin
    logic [3:0] lv, hist1, hist2;
    logic prev_l3, exp_t, exp_c;
    bit idle_now, idle_1, idle_2;
    int unsigned seed;
    seed = $urandom(32'd24681);
    rst = 1'b1; trig_i = 1'b1; cmd_i = 1'b1;
    hist1 = '0; hist2 = '0; idle_1 = 0; idle_2 = 0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check("R1 reset outputs", {2'b00, line_o, stb_o}, 4'b0000);
    end
    rst = 1'b0; trig_i = 1'b1; cmd_i = 1'b1;
    // R7: partial period uses held reset bits 0
    @(negedge clk); check("R7 post-reset half1", {2'b0, line_o, stb_o}, 4'b0000);
    @(negedge clk); check("R7 post-reset half2", {2'b0, line_o, stb_o}, 4'b0010);
    @(negedge clk); check("R7 post-reset half3", {2'b0, line_o, stb_o}, 4'b0010);
    prev_l3 = line_o;
    exp_t = 1'b0; exp_c = 1'b1; idle_now = 1;
    trig_i = exp_t; cmd_i = exp_c;
    for (int p = 0; p < 400; p++) begin
      for (int h = 0; h < 4; h++) begin
        @(negedge clk);
        lv[h] = line_o;
        // R2: strobe exactly in half-cell 0
        check("R2 strobe position", {3'b0, stb_o}, {3'b0, (h == 0)});
        if (h != 3) begin
          // R5: noise between captures must not matter
          trig_i = 1'($urandom);
          cmd_i  = 1'($urandom);
        end
      end
      // R6: full period levels at fixed offsets from capture
      check("R6 period levels", lv, exp_levels(prev_l3, exp_t, exp_c));
      // R4/R5: decoder recovers captured pair
      check("R4 R5 decoded pair", {2'b0, lv[1] != lv[0], lv[3] != lv[2]}, {2'b0, exp_t, exp_c});
      // R3: transitions at both cell boundaries
      check("R3 cell boundaries", {2'b0, lv[0] != prev_l3, lv[2] != lv[1]}, 4'b0011);
      if (idle_now && idle_1) check("R8 idle inverts", lv, ~hist1);
      if (idle_now && idle_1 && idle_2) check("R8 idle repeats", lv, hist2);
      hist2 = hist1; hist1 = lv; idle_2 = idle_1; idle_1 = idle_now;
      prev_l3 = lv[3];
      // next captured pair, driven in half-cell 3
      if (p < 20)      begin exp_t = 1'b0; exp_c = 1'b1; end
      else if (p < 30) begin exp_t = 1'b0; exp_c = 1'b0; end
      else if (p < 40) begin exp_t = 1'b1; exp_c = 1'b1; end
      else if (p < 48) begin exp_t = 1'b0; exp_c = 1'b1; end
      else begin exp_t = 1'($urandom); exp_c = 1'($urandom); end
      idle_now = (!exp_t && exp_c);
      trig_i = exp_t; cmd_i = exp_c;
    end
    // R1: re-entering reset mid-stream
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset again", {2'b00, line_o, stb_o}, 4'b0000);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule